// File: doc/BRIEF.md
# Operand Forwarding Unit

This block picks, for each of the two ALU operands of the execute stage in a five-stage in-order pipeline, where the operand comes from. The sources are the value read from the register file (latched with the instruction), the ALU result of the instruction one slot ahead (now in the memory stage), and the final writeback value of the instruction two slots ahead. The register file is expected to pass a write through to a same-cycle read, so producers three or more slots ahead need no bypass at all.

It also watches the boundary between decode and execute. When the instruction in execute is a load, its data exists only at the end of the memory stage. A dependent instruction sitting in decode therefore cannot be served in time by any bypass, and the block requests a one-cycle stall. All outputs are combinational, so the selects and the stall are valid in the same cycle as the inputs. The block holds no state.

Top module: `bypass_ctrl`

## Requirements
- R1: When an execute source index is nonzero, equals the memory-stage destination, and the memory-stage write flag is set, that operand's select is 2'b10 and the operand output equals the memory-stage ALU result.
- R2: When R1 does not apply but the same three conditions hold against the writeback-stage destination and write flag, the select is 2'b01 and the operand output equals the writeback data.
- R3: When neither R1 nor R2 applies, the select is 2'b00 and the operand output equals the register-file value for that operand.
- R4: When both the memory and writeback stages would match, the memory stage (the younger producer) wins.
- R5: A source index of zero is never forwarded, even if a stage with its write flag set names destination zero.
- R6: The two operands are resolved independently: one may forward from the memory stage while the other forwards from writeback or uses the register file.
- R7: The stall output is 1 when the execute instruction is a load, its destination is nonzero, and that destination equals a decode source whose use flag is set.
- R8: The stall output is 0 when the execute instruction is not a load, when the load's destination is zero, or when the only matching decode source has its use flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | IDX_W | First source index of the execute instruction |
| ex_rt | input | IDX_W | Second source index of the execute instruction |
| ex_rd | input | IDX_W | Destination index of the execute instruction |
| ex_is_load | input | 1 | Execute instruction reads data memory |
| mem_rd | input | IDX_W | Destination index in the memory stage |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | IDX_W | Destination index in the writeback stage |
| wb_we | input | 1 | Writeback-stage instruction writes a register |
| id_rs | input | IDX_W | First source index of the decode instruction |
| id_rt | input | IDX_W | Second source index of the decode instruction |
| id_use_rs | input | 1 | Decode instruction actually reads its first source |
| id_use_rt | input | 1 | Decode instruction actually reads its second source |
| rf_a | input | DATA_W | Register-file value for the first operand |
| rf_b | input | DATA_W | Register-file value for the second operand |
| mem_alu | input | DATA_W | ALU result held in the memory stage |
| wb_data | input | DATA_W | Selected writeback value (load data or ALU result) |
| sel_a | output | 2 | Source select for the first operand |
| sel_b | output | 2 | Source select for the second operand |
| op_a | output | DATA_W | Resolved first operand |
| op_b | output | DATA_W | Resolved second operand |
| stall | output | 1 | Load-use stall request |

## Verification
The bench builds the block with its defaults, five-bit register indices and 32-bit data, so the full index range including register zero and the top register 31 is reachable. Each scenario uses distinct data words on the three sources, so a wrong select shows up as a wrong operand value as well as a wrong select code. The stall scenarios vary which decode source matches and whether its use flag is set, to separate the load-use path from the bypass path.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_MEM = 2'b10
    } fwd_src_e;
endpackage

// File: rtl/fwd_pick.sv
module fwd_pick
    import bypass_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] src,
    input  logic [IDX_W-1:0] mem_rd,
    input  logic             mem_we,
    input  logic [IDX_W-1:0] wb_rd,
    input  logic             wb_we,
    output fwd_src_e         sel
);
    logic src_live;
    logic hit_mem;
    logic hit_wb;

    always_comb begin
        src_live = (src != '0);
        hit_mem  = src_live && mem_we && (src == mem_rd);
        hit_wb   = src_live && wb_we  && (src == wb_rd);
        if (hit_mem)
            sel = SRC_MEM;
        else if (hit_wb)
            sel = SRC_WB;
        else
            sel = SRC_RF;
    end
endmodule

// File: rtl/operand_mux.sv
module operand_mux
    import bypass_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_src_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] op
);
    always_comb begin
        unique case (sel)
            SRC_MEM: op = mem_val;
            SRC_WB:  op = wb_val;
            default: op = rf_val;
        endcase
    end
endmodule

// File: rtl/load_use_det.sv
module load_use_det #(
    parameter int IDX_W = 5
) (
    input  logic             ex_is_load,
    input  logic [IDX_W-1:0] ex_rd,
    input  logic [IDX_W-1:0] id_rs,
    input  logic [IDX_W-1:0] id_rt,
    input  logic             id_use_rs,
    input  logic             id_use_rt,
    output logic             stall
);
    logic dest_live;
    logic dep_rs;
    logic dep_rt;

    always_comb begin
        dest_live = ex_is_load && (ex_rd != '0);
        dep_rs    = id_use_rs && (id_rs == ex_rd);
        dep_rt    = id_use_rt && (id_rt == ex_rd);
        stall     = dest_live && (dep_rs || dep_rt);
    end
endmodule

// File: rtl/bypass_ctrl.sv
module bypass_ctrl
    import bypass_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [IDX_W-1:0]  ex_rs,
    input  logic [IDX_W-1:0]  ex_rt,
    input  logic [IDX_W-1:0]  ex_rd,
    input  logic              ex_is_load,
    input  logic [IDX_W-1:0]  mem_rd,
    input  logic              mem_we,
    input  logic [IDX_W-1:0]  wb_rd,
    input  logic              wb_we,
    input  logic [IDX_W-1:0]  id_rs,
    input  logic [IDX_W-1:0]  id_rt,
    input  logic              id_use_rs,
    input  logic              id_use_rt,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic [DATA_W-1:0] mem_alu,
    input  logic [DATA_W-1:0] wb_data,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b,
    output logic              stall
);
    localparam int N_OPS = 2;

    logic [IDX_W-1:0]  src_v [N_OPS];
    logic [DATA_W-1:0] rf_v  [N_OPS];
    logic [DATA_W-1:0] op_v  [N_OPS];
    fwd_src_e          sel_v [N_OPS];

    assign src_v[0] = ex_rs;
    assign src_v[1] = ex_rt;
    assign rf_v[0]  = rf_a;
    assign rf_v[1]  = rf_b;

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        fwd_pick #(.IDX_W(IDX_W)) u_pick (
            .src    (src_v[g]),
            .mem_rd (mem_rd),
            .mem_we (mem_we),
            .wb_rd  (wb_rd),
            .wb_we  (wb_we),
            .sel    (sel_v[g])
        );
        operand_mux #(.DATA_W(DATA_W)) u_mux (
            .sel     (sel_v[g]),
            .rf_val  (rf_v[g]),
            .mem_val (mem_alu),
            .wb_val  (wb_data),
            .op      (op_v[g])
        );
    end

    assign sel_a = sel_v[0];
    assign sel_b = sel_v[1];
    assign op_a  = op_v[0];
    assign op_b  = op_v[1];

    load_use_det #(.IDX_W(IDX_W)) u_lud (
        .ex_is_load (ex_is_load),
        .ex_rd      (ex_rd),
        .id_rs      (id_rs),
        .id_rt      (id_rt),
        .id_use_rs  (id_use_rs),
        .id_use_rt  (id_use_rt),
        .stall      (stall)
    );

    always_comb begin
        // R1
        mem_path_chk: assert (sel_a != SRC_MEM || op_a == mem_alu)
            else $error("operand A select MEM but value differs");
        // R2
        wb_path_chk: assert (sel_b != SRC_WB || op_b == wb_data)
            else $error("operand B select WB but value differs");
        // R3
        rf_path_chk: assert (sel_a != SRC_RF || op_a == rf_a)
            else $error("operand A select RF but value differs");
        // R4
        young_first_chk: assert (!(ex_rs != '0 && mem_we && ex_rs == mem_rd) || sel_a == SRC_MEM)
            else $error("memory-stage producer not preferred");
        // R5
        zero_src_chk: assert ((ex_rs != '0 || sel_a == SRC_RF) && (ex_rt != '0 || sel_b == SRC_RF))
            else $error("register zero forwarded");
        // R8
        stall_load_chk: assert (!stall || (ex_is_load && ex_rd != '0))
            else $error("stall without a live load in execute");
    end
endmodule

// File: tb/bypass_ctrl_test.sv
module bypass_ctrl_test;
    localparam int IW = 5;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [IW-1:0] ex_rs, ex_rt, ex_rd, mem_rd, wb_rd, id_rs, id_rt;
    logic          ex_is_load, mem_we, wb_we, id_use_rs, id_use_rt;
    logic [DW-1:0] rf_a, rf_b, mem_alu, wb_data;
    logic [1:0]    sel_a, sel_b;
    logic [DW-1:0] op_a, op_b;
    logic          stall;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    bypass_ctrl #(.IDX_W(IW), .DATA_W(DW)) uut (
        .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
        .id_rs(id_rs), .id_rt(id_rt), .id_use_rs(id_use_rs), .id_use_rt(id_use_rt),
        .rf_a(rf_a), .rf_b(rf_b), .mem_alu(mem_alu), .wb_data(wb_data),
        .sel_a(sel_a), .sel_b(sel_b), .op_a(op_a), .op_b(op_b), .stall(stall)
    );

    localparam logic [DW-1:0] VA = 32'h1111_AAAA;
    localparam logic [DW-1:0] VB = 32'h2222_BBBB;
    localparam logic [DW-1:0] VM = 32'h3333_CCCC;
    localparam logic [DW-1:0] VW = 32'h4444_DDDD;

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        ex_rs = '0; ex_rt = '0; ex_rd = '0; ex_is_load = 1'b0;
        mem_rd = '0; mem_we = 1'b0; wb_rd = '0; wb_we = 1'b0;
        id_rs = '0; id_rt = '0; id_use_rs = 1'b0; id_use_rt = 1'b0;
        rf_a = VA; rf_b = VB; mem_alu = VM; wb_data = VW;
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic t_idle();
        idle(); settle();
        chk("R3 idle sel_a", 32'(sel_a), 32'd0);
        chk("R3 idle op_b", op_b, VB);
        chk("R8 idle stall", 32'(stall), 32'd0);
    endtask

    task automatic t_mem_fwd();
        idle();
        ex_rs = 5'd7; mem_rd = 5'd7; mem_we = 1'b1;
        settle();
        chk("R1 sel_a", 32'(sel_a), 32'd2);
        chk("R1 op_a", op_a, VM);
        chk("R6 op_b untouched", op_b, VB);
    endtask

    task automatic t_wb_fwd();
        idle();
        ex_rt = 5'd31; wb_rd = 5'd31; wb_we = 1'b1;
        settle();
        chk("R2 sel_b", 32'(sel_b), 32'd1);
        chk("R2 op_b", op_b, VW);
    endtask

    task automatic t_no_write();
        idle();
        ex_rs = 5'd9; mem_rd = 5'd9; wb_rd = 5'd9;
        settle();
        chk("R3 write flags clear sel_a", 32'(sel_a), 32'd0);
        chk("R3 write flags clear op_a", op_a, VA);
    endtask

    task automatic t_priority();
        idle();
        ex_rs = 5'd4; mem_rd = 5'd4; mem_we = 1'b1; wb_rd = 5'd4; wb_we = 1'b1;
        settle();
        chk("R4 sel_a", 32'(sel_a), 32'd2);
        chk("R4 op_a", op_a, VM);
    endtask

    task automatic t_zero();
        idle();
        mem_we = 1'b1; wb_we = 1'b1;
        settle();
        chk("R5 sel_a", 32'(sel_a), 32'd0);
        chk("R5 op_b", op_b, VB);
    endtask

    task automatic t_split();
        idle();
        ex_rs = 5'd3; ex_rt = 5'd5;
        mem_rd = 5'd5; mem_we = 1'b1; wb_rd = 5'd3; wb_we = 1'b1;
        settle();
        chk("R6 sel_a", 32'(sel_a), 32'd1);
        chk("R6 op_a", op_a, VW);
        chk("R6 sel_b", 32'(sel_b), 32'd2);
        chk("R6 op_b", op_b, VM);
    endtask

    task automatic t_stall_rs();
        idle();
        ex_is_load = 1'b1; ex_rd = 5'd12; id_rs = 5'd12; id_use_rs = 1'b1;
        settle();
        chk("R7 stall rs", 32'(stall), 32'd1);
    endtask

    task automatic t_stall_rt();
        idle();
        ex_is_load = 1'b1; ex_rd = 5'd20; id_rt = 5'd20; id_use_rt = 1'b1; id_rs = 5'd1; id_use_rs = 1'b1;
        settle();
        chk("R7 stall rt", 32'(stall), 32'd1);
    endtask

    task automatic t_no_stall();
        idle();
        ex_is_load = 1'b1; ex_rd = 5'd12; id_rs = 5'd12; id_use_rs = 1'b0;
        settle();
        chk("R8 unused source", 32'(stall), 32'd0);
        idle();
        ex_is_load = 1'b1; ex_rd = 5'd0; id_rs = 5'd0; id_use_rs = 1'b1;
        settle();
        chk("R8 load dest zero", 32'(stall), 32'd0);
        idle();
        ex_is_load = 1'b0; ex_rd = 5'd12; id_rt = 5'd12; id_use_rt = 1'b1;
        settle();
        chk("R8 not a load", 32'(stall), 32'd0);
    endtask

    initial begin
        t_idle();
        t_mem_fwd();
        t_wb_fwd();
        t_no_write();
        t_priority();
        t_zero();
        t_split();
        t_stall_rs();
        t_stall_rt();
        t_no_stall();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule